// File: doc/BRIEF.md
# Segmented CRC Generator and Appender

This block encodes a serial bit stream with cyclic redundancy checksums. Each frame is treated as a run of equal-length subframes. Every data bit is forwarded to the output unchanged and in arrival order. When a subframe's last bit has been accepted, the block emits that subframe's r-bit checksum before it accepts any more input. A frame of m bits therefore leaves the block as m + k·r bits, where k = m / SUBFRAME_LEN.

Several settings are fixed at compile time:
- the generator polynomial, of any degree r ≥ 1, given as r+1 coefficients with the highest power first;
- the starting register value;
- the subframe length;
- the update style, either augmented or direct;
- byte reversal of the bits fed to the register;
- end-to-end reversal of the finished checksum;
- an output XOR mask.

Both sides of the block use a valid/ready handshake. A start marker on the input tags the first bit of a frame. A scalar starting value or mask is expressed by replicating it across the parameter vector.

Top module: `segcrc_gen`

## Requirements
- R1: Every accepted input bit appears on `outData` in the same cycle, unchanged and in order. Each subframe of SUB_LEN data bits is followed by exactly CRC_W checksum bits, so a frame of m bits produces m + (m/SUB_LEN)·CRC_W output bits.
- R2: With DIRECT=0, the checksum is computed as follows. INIT (MSB first) is prefixed to the subframe data, and CRC_W zero bits are appended. The checksum is the remainder of this sequence divided by POLY. It is sent MSB first, and an all-zero INIT leaves it unaffected.
- R3: The register restarts from INIT at the first bit of every subframe, so two subframes with identical data receive identical checksums.
- R4: With DIRECT=1, the register starts at INIT. For each bit, feedback = bit XOR register MSB. The register then shifts left with a 0 entering, and the low CRC_W coefficients of POLY are XORed in when the feedback is 1. No prefix and no trailing zeros are used.
- R5: With REFLECT_IN=1, the register consumes each byte in reverse order: the 8th received bit of the byte first and the 1st received bit last. The output data order is unchanged. SUB_LEN must then be a multiple of 8.
- R6: With REFLECT_OUT=1, the finished register value is reversed end to end. XOR_OUT is then XORed in, and the result is emitted MSB first.
- R7: While the checksum is being emitted, `outValid` stays high and `inReady` stays low. Exactly CRC_W output beats take place before the next input bit is accepted.
- R8: When `outReady` is low, no bit is lost or repeated. A pending checksum bit stays valid and stable until it is taken.
- R9: A bit accepted with `inStart` high counts as the first bit of a new subframe, and any partial subframe is abandoned without a checksum.
- R10: Synchronous active-high reset returns the block to the data phase. With `inValid` low after reset, `outValid` is 0 and `inReady` equals `outReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input bit is valid |
| inStart | input | 1 | Input bit is the first of a frame |
| inData | input | 1 | Input data bit |
| inReady | output | 1 | Block accepts the input bit this cycle |
| outValid | output | 1 | Output bit is valid |
| outReady | input | 1 | Downstream accepts the output bit |
| outData | output | 1 | Output bit: a forwarded data bit or a checksum bit |

## Verification
Forwarded data bits are due in the same cycle as their input beat. The first checksum bit is due in the cycle after the last data beat of a subframe. Each further checksum bit is due one accepted output cycle later, and input acceptance resumes in the cycle after the final checksum beat. The bench drives inputs just after the rising edge and records every output beat at the falling edge, so each recorded bit is the value the downstream side takes at the next edge. Expected checksums come from a bench-side long-division or recurrence model applied to the recorded stream. The stall length is measured by counting falling edges where input is offered but not accepted while `outReady` is high.

// File: rtl/segcrc_pkg.sv
package segcrc_pkg;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_CRC  = 1'b1
  } segPhase_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic       accept;    // data beat accepted this cycle
    logic       first;     // beat is bit 0 of a subframe
    logic       last;      // beat is the final bit of a subframe
    logic       crcPhase;  // checksum is being emitted
    logic       crcShift;  // checksum bit taken this cycle
    logic [2:0] bitPos;    // position of the beat within its byte
  } segStrobe_t;

endpackage

// File: rtl/segcrc_ctrl.sv
module segcrc_ctrl
  import segcrc_pkg::*;
#(
  parameter int unsigned SUB_LEN = 8,
  parameter int unsigned CRC_W   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output segStrobe_t strb
);

  localparam int unsigned CNT_RAW   = $clog2(SUB_LEN + 1);
  localparam int unsigned CNT_W     = (CNT_RAW > 3) ? CNT_RAW : 3;
  localparam int unsigned CRC_CNT_W = $clog2(CRC_W + 1);
  localparam logic [CNT_W-1:0]     LAST_IDX = CNT_W'(SUB_LEN - 1);
  localparam logic [CRC_CNT_W-1:0] CRC_LAST = CRC_CNT_W'(CRC_W - 1);

  segPhase_e            phase;
  logic [CNT_W-1:0]     bitCnt;
  logic [CNT_W-1:0]     curIdx;
  logic [CRC_CNT_W-1:0] crcCnt;
  logic                 accept;
  logic                 isLast;

  always_comb begin
    curIdx   = inStart ? '0 : bitCnt;
    accept   = (phase == PH_DATA) && inValid && outReady;
    isLast   = (curIdx == LAST_IDX);
    inReady  = (phase == PH_DATA) && outReady;
    outValid = (phase == PH_DATA) ? inValid : 1'b1;

    strb.accept   = accept;
    strb.first    = (curIdx == '0);
    strb.last     = isLast;
    strb.crcPhase = (phase == PH_CRC);
    strb.crcShift = (phase == PH_CRC) && outReady;
    strb.bitPos   = curIdx[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_DATA;
      bitCnt <= '0;
      crcCnt <= '0;
    end else if (phase == PH_DATA) begin
      if (accept) begin
        if (isLast) begin
          bitCnt <= '0;
          crcCnt <= '0;
          phase  <= PH_CRC;
        end else begin
          bitCnt <= curIdx + CNT_W'(1);
        end
      end
    end else if (outReady) begin
      if (crcCnt == CRC_LAST) begin
        phase <= PH_DATA;
      end else begin
        crcCnt <= crcCnt + CRC_CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/segcrc_datapath.sv
module segcrc_datapath
  import segcrc_pkg::*;
#(
  parameter int unsigned      CRC_W       = 3,
  parameter logic [CRC_W:0]   POLY        = 4'b1011,
  parameter logic [CRC_W-1:0] INIT        = '0,
  parameter bit               DIRECT      = 1'b0,
  parameter bit               REFLECT_IN  = 1'b0,
  parameter bit               REFLECT_OUT = 1'b0,
  parameter logic [CRC_W-1:0] XOR_OUT     = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  segStrobe_t strb,
  input  logic       inData,
  output logic       outData
);

  localparam logic [CRC_W-1:0] POLY_LOW = POLY[CRC_W-1:0];

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcBase;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] outSh;
  logic [6:0]       byteBuf;

  // One register update for one message bit
  function automatic logic [CRC_W-1:0] stepBit(input logic [CRC_W-1:0] s, input logic b);
    logic             fb;
    logic [CRC_W-1:0] r;
    if (DIRECT) begin
      fb = b ^ s[CRC_W-1];
      r  = s << 1;
    end else begin
      fb = s[CRC_W-1];
      r  = (s << 1) | CRC_W'(b);
    end
    return fb ? (r ^ POLY_LOW) : r;
  endfunction

  // Augmentation, optional reversal and output mask
  function automatic logic [CRC_W-1:0] finishCrc(input logic [CRC_W-1:0] s);
    logic [CRC_W-1:0] r;
    logic [CRC_W-1:0] v;
    r = s;
    if (!DIRECT) begin
      for (int i = 0; i < CRC_W; i++) r = stepBit(r, 1'b0);
    end
    v = r;
    if (REFLECT_OUT) begin
      for (int i = 0; i < CRC_W; i++) v[i] = r[CRC_W-1-i];
    end
    return v ^ XOR_OUT;
  endfunction

  always_comb begin
    crcBase = strb.first ? INIT : crcReg;
    crcNext = crcBase;
    if (REFLECT_IN) begin
      if (strb.bitPos == 3'd7) begin
        crcNext = stepBit(crcNext, inData);
        for (int j = 0; j < 7; j++) crcNext = stepBit(crcNext, byteBuf[j]);
      end
    end else begin
      crcNext = stepBit(crcBase, inData);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg  <= INIT;
      byteBuf <= '0;
    end else if (strb.accept) begin
      crcReg  <= crcNext;
      byteBuf <= {byteBuf[5:0], inData};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outSh <= '0;
    end else if (strb.accept && strb.last) begin
      outSh <= finishCrc(crcNext);
    end else if (strb.crcShift) begin
      outSh <= outSh << 1;
    end
  end

  assign outData = strb.crcPhase ? outSh[CRC_W-1] : inData;

endmodule

// File: rtl/segcrc_gen.sv
module segcrc_gen
  import segcrc_pkg::*;
#(
  parameter int unsigned      CRC_W       = 3,
  parameter logic [CRC_W:0]   POLY        = 4'b1011,
  parameter logic [CRC_W-1:0] INIT        = '0,
  parameter int unsigned      SUB_LEN     = 8,
  parameter bit               DIRECT      = 1'b0,
  parameter bit               REFLECT_IN  = 1'b0,
  parameter bit               REFLECT_OUT = 1'b0,
  parameter logic [CRC_W-1:0] XOR_OUT     = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inStart,
  input  logic inData,
  output logic inReady,
  output logic outValid,
  input  logic outReady,
  output logic outData
);

  segStrobe_t strb;

  segcrc_ctrl #(
    .SUB_LEN (SUB_LEN),
    .CRC_W   (CRC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inStart  (inStart),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  segcrc_datapath #(
    .CRC_W       (CRC_W),
    .POLY        (POLY),
    .INIT        (INIT),
    .DIRECT      (DIRECT),
    .REFLECT_IN  (REFLECT_IN),
    .REFLECT_OUT (REFLECT_OUT),
    .XOR_OUT     (XOR_OUT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/segcrc_checker.sv
module segcrc_checker #(
  parameter int unsigned CRC_W = 3
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inReady,
  input logic inData,
  input logic outValid,
  input logic outReady,
  input logic outData,
  input logic crcPhase
);

  localparam int unsigned RUN_W = $clog2(CRC_W + 1) + 1;

  logic [RUN_W-1:0] crcRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      crcRun <= '0;
    end else if (inValid && inReady) begin
      crcRun <= '0;
    end else if (crcPhase && outReady) begin
      crcRun <= crcRun + RUN_W'(1);
    end
  end

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> (outValid && (outData == inData))); // R1

  AST_CRC_VALID: assert property (@(posedge clk) disable iff (rst)
    crcPhase |-> (outValid && !inReady)); // R7

  AST_CRC_BOUND: assert property (@(posedge clk) disable iff (rst)
    crcRun <= RUN_W'(CRC_W)); // R7

  AST_CRC_FULL: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (crcRun != '0)) |-> (crcRun == RUN_W'(CRC_W))); // R7

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (crcPhase && !outReady) |=> (crcPhase && outValid && $stable(outData))); // R8

endmodule

bind segcrc_gen segcrc_checker #(.CRC_W(CRC_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .crcPhase (strb.crcPhase)
);

// File: tb/tb_segcrc_gen.sv
module tb_segcrc_gen;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic inValid = 1'b0;
  logic inStart = 1'b0;
  logic inData  = 1'b0;
  logic outReady = 1'b1;
  logic sel = 1'b0;
  logic bpOn = 1'b0;
  int   bpCnt = 0;

  logic rdyA, vA, dA, rdyB, vB, dB;
  logic curReady, curValid, curData;

  // Config A: degree 3, augmented, nonzero start value
  segcrc_gen #(
    .CRC_W(3), .POLY(4'b1011), .INIT(3'b101), .SUB_LEN(8),
    .DIRECT(1'b0), .REFLECT_IN(1'b0), .REFLECT_OUT(1'b0), .XOR_OUT(3'b000)
  ) dut (
    .clk(clk), .rst(rst), .inValid(inValid && !sel), .inStart(inStart),
    .inData(inData), .inReady(rdyA), .outValid(vA), .outReady(outReady), .outData(dA)
  );

  // Config B: degree 5, direct, both reflections, output mask
  segcrc_gen #(
    .CRC_W(5), .POLY(6'b100101), .INIT(5'b11111), .SUB_LEN(16),
    .DIRECT(1'b1), .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1), .XOR_OUT(5'b10110)
  ) dutB (
    .clk(clk), .rst(rst), .inValid(inValid && sel), .inStart(inStart),
    .inData(inData), .inReady(rdyB), .outValid(vB), .outReady(outReady), .outData(dB)
  );

  assign curReady = sel ? rdyB : rdyA;
  assign curValid = sel ? vB : vA;
  assign curData  = sel ? dB : dA;

  int checks = 0;
  int fails  = 0;
  bit txBits [0:63];
  bit rxBits [0:255];
  int rxCnt = 0;
  int stallCnt = 0;
  int stallValid = 0;
  bit finished = 1'b0;

  always begin
    @(posedge clk);
    #2;
    if (bpOn) begin
      bpCnt++;
      outReady = ((bpCnt % 3) != 0);
    end else begin
      outReady = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (curValid && outReady) begin
        if (rxCnt < 256) rxBits[rxCnt] = curData;
        rxCnt++;
      end
      if (inValid && outReady && !curReady) begin
        stallCnt++;
        if (curValid) stallValid++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refCrc(input bit isB, input int base, input int len);
    int w, poly, init, rem, mask, b, fb, rv;
    w    = isB ? 5 : 3;
    poly = isB ? 'h25 : 'hB;
    init = isB ? 'h1F : 'h5;
    mask = (1 << w) - 1;
    if (!isB) begin
      rem = 0;
      for (int i = w - 1; i >= 0; i--) begin
        rem = (rem << 1) | ((init >> i) & 1);
        if ((rem >> w) & 1) rem = rem ^ poly;
      end
      for (int i = 0; i < len + w; i++) begin
        b = (i < len) ? int'(txBits[base + i]) : 0;
        rem = (rem << 1) | b;
        if ((rem >> w) & 1) rem = rem ^ poly;
      end
      return rem & mask;
    end
    rem = init;
    for (int i = 0; i < len; i++) begin
      b   = int'(txBits[base + (i / 8) * 8 + (7 - (i % 8))]);
      fb  = b ^ ((rem >> (w - 1)) & 1);
      rem = (rem << 1) & mask;
      if (fb != 0) rem = rem ^ (poly & mask);
    end
    rv = 0;
    for (int i = 0; i < w; i++) rv = rv | (((rem >> i) & 1) << (w - 1 - i));
    return rv ^ 'h16;
  endfunction

  function automatic int rxField(input int start, input int w);
    int v = 0;
    for (int j = 0; j < w; j++) v = (v << 1) | int'(rxBits[start + j]);
    return v;
  endfunction

  task automatic clearRx();
    rxCnt = 0;
    stallCnt = 0;
    stallValid = 0;
  endtask

  task automatic pushBit(input bit b, input bit st);
    inValid = 1'b1;
    inData  = b;
    inStart = st;
    @(negedge clk);
    while (!curReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inStart = 1'b0;
    inData  = 1'b0;
  endtask

  task automatic sendFrame(input int base, input int n);
    for (int i = 0; i < n; i++) pushBit(txBits[base + i], i == 0);
  endtask

  task automatic drain(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadBytes(input int base, input logic [31:0] val, input int nbytes);
    for (int i = 0; i < nbytes * 8; i++) txBits[base + i] = val[nbytes * 8 - 1 - i];
  endtask

  task automatic checkStream(input bit isB, input int nsub, input string tag);
    int sub, w, idx, mism, got, exp;
    sub = isB ? 16 : 8;
    w   = isB ? 5 : 3;
    idx = 0;
    check(rxCnt == nsub * (sub + w), {"R1 output length ", tag}, rxCnt, nsub * (sub + w));
    for (int s = 0; s < nsub; s++) begin
      mism = 0;
      for (int i = 0; i < sub; i++) if (rxBits[idx + i] != txBits[s * sub + i]) mism++;
      check(mism == 0, {"R1 data passthrough ", tag}, mism, 0);
      got = rxField(idx + sub, w);
      exp = refCrc(isB, s * sub, sub);
      if (isB) check(got == exp, {"R4 R5 R6 checksum ", tag}, got, exp);
      else     check(got == exp, {"R2 checksum ", tag}, got, exp);
      idx += sub + w;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(vA == 1'b0, "R10 outValid idle A", int'(vA), 0);
    check(rdyA == 1'b1, "R10 inReady after reset A", int'(rdyA), 1);
    check(vB == 1'b0, "R10 outValid idle B", int'(vB), 0);
    check(rdyB == 1'b1, "R10 inReady after reset B", int'(rdyB), 1);
    drain(1);
  endtask

  task automatic testBasicA();
    sel = 1'b0;
    clearRx();
    loadBytes(0, 32'h0000A53C, 2);
    sendFrame(0, 16);
    drain(10);
    checkStream(1'b0, 2, "A basic");
    check(stallCnt == 3, "R7 stall cycles A", stallCnt, 3);
    check(stallValid == 3, "R7 outValid during stall A", stallValid, 3);
  endtask

  task automatic testRestartEach();
    int c0, c1;
    sel = 1'b0;
    clearRx();
    loadBytes(0, 32'h00006E6E, 2);
    sendFrame(0, 16);
    drain(10);
    checkStream(1'b0, 2, "A repeated");
    c0 = rxField(8, 3);
    c1 = rxField(19, 3);
    check(c0 == c1, "R3 identical subframes same checksum", c1, c0);
  endtask

  task automatic testZeroData();
    sel = 1'b0;
    clearRx();
    loadBytes(0, 32'h00000000, 2);
    sendFrame(0, 16);
    drain(10);
    checkStream(1'b0, 2, "A zero data");
  endtask

  task automatic testBackpressure();
    sel = 1'b0;
    clearRx();
    loadBytes(0, 32'h00000FF0, 2);
    bpOn = 1'b1;
    sendFrame(0, 16);
    drain(30);
    bpOn = 1'b0;
    drain(3);
    checkStream(1'b0, 2, "R8 backpressure");
  endtask

  task automatic testMidRestart();
    int got, exp, mism;
    sel = 1'b0;
    clearRx();
    txBits[0] = 1'b1; txBits[1] = 1'b0; txBits[2] = 1'b1;
    loadBytes(3, 32'h000000C9, 1);
    for (int i = 0; i < 3; i++) pushBit(txBits[i], i == 0);
    for (int i = 0; i < 8; i++) pushBit(txBits[3 + i], i == 0);
    drain(10);
    check(rxCnt == 14, "R9 length after restart", rxCnt, 14);
    mism = 0;
    for (int i = 0; i < 11; i++) if (rxBits[i] != txBits[i]) mism++;
    check(mism == 0, "R9 data before checksum", mism, 0);
    got = rxField(11, 3);
    exp = refCrc(1'b0, 3, 8);
    check(got == exp, "R9 checksum covers new subframe only", got, exp);
  endtask

  task automatic testConfigB();
    sel = 1'b1;
    clearRx();
    loadBytes(0, 32'h1234ABCD, 4);
    sendFrame(0, 32);
    drain(12);
    checkStream(1'b1, 2, "B");
    check(stallCnt == 5, "R7 stall cycles B", stallCnt, 5);
    sel = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    testReset();
    testBasicA();
    testRestartEach();
    testZeroData();
    testBackpressure();
    testMidRestart();
    testConfigB();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule